// File: doc/BRIEF.md
# Channel Setup Sequencer with Conversion FIFO

This block steps a converter through a programmable list of up to sixteen channel setups and collects the results in a small data FIFO. Software loads the setups two at a time through a 24-bit pair word, then pulses a start input along with the mode bits. The sequencer presents the active setup (its channel field and its two latch bits included) and holds a conversion request until the converter returns a done strobe with a data word. That word is pushed into the FIFO, which a serial port drains through a show-ahead read interface.

Three mode bits and a 4-bit end index decide how the run behaves. The multi bit chooses between the whole list from entry 0 up to the end index and a single entry named by a start pointer. The loop bit chooses between one pass and endless repetition. The wait bit makes a looping run pause after each pass until the FIFO has been emptied. The FIFO capacity always equals the pass length. If a word arrives while the FIFO is full, the oldest word is discarded and a sticky overflow flag is set.

Top module: `chan_seq_fifo`

## Requirements
- R1: After reset, convReq, seqBusy, seqDone, fifoOvf and fifoCount are 0 and fifoEmpty is 1.
- R2: A write of pair word p loads its bits 23:12 into setup 2p and its bits 11:0 into setup 2p+1. While a conversion is requested, convSetup shows the whole 12-bit active setup.
- R3: While converting, convChan equals bits 2:0 of the active setup and latchOut equals its bits 11:10.
- R4: With cfgMulti=1, setups are converted in ascending order from 0 to cfgDepth, and each accepted convDone advances to the next setup.
- R5: With cfgMulti=0, only the setup selected by startPtr is converted.
- R6: With cfgLoop=0, the block returns to idle after the last conversion of the pass. It then drops convReq and seqBusy and raises seqDone, which stays high until the next start.
- R7: With cfgLoop=1 and cfgWaitRead=0, the block goes back to the first setup right after the last one and keeps requesting.
- R8: With cfgLoop=1 and cfgWaitRead=1, convReq stays low after a full pass until the FIFO is empty. The pass then restarts at the first setup.
- R9: Each accepted convDone pushes convData into the FIFO, and words are read in arrival order. The capacity equals the number of setups in the pass, and fifoRdData shows the oldest word.
- R10: A push into a full FIFO with no read in that cycle discards the oldest word, keeps the count, and sets fifoOvf. fifoOvf stays set until the next start, and a start also empties the FIFO.
- R11: startReq while busy, and convDone while no conversion is requested, have no effect.
- R12: fifoRdEn while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| setupWrEn | input | 1 | Write strobe for a setup pair |
| setupWrAddr | input | 3 | Pair index |
| setupWrData | input | 24 | Pair word, even setup in the upper half |
| cfgLoop | input | 1 | Repeat the pass |
| cfgMulti | input | 1 | Run the list 0..cfgDepth rather than one setup |
| cfgWaitRead | input | 1 | Pause after each pass until the FIFO is empty |
| cfgDepth | input | 4 | Index of the last setup in a multi-setup pass |
| startReq | input | 1 | Start pulse, taken only when idle |
| startPtr | input | 4 | Setup used when cfgMulti=0 |
| convReq | output | 1 | Conversion requested on the active setup |
| convSetup | output | 12 | Active setup word |
| convChan | output | 3 | Channel field of the active setup |
| latchOut | output | 2 | Latch bits of the active setup |
| convDone | input | 1 | Conversion finished strobe |
| convData | input | 24 | Conversion result |
| fifoRdEn | input | 1 | Pop the oldest FIFO word |
| fifoRdData | output | 24 | Oldest FIFO word |
| fifoEmpty | output | 1 | FIFO holds no word |
| fifoCount | output | 5 | Number of words held |
| fifoOvf | output | 1 | Sticky overflow flag |
| seqBusy | output | 1 | Sequencer not idle |
| seqDone | output | 1 | Single-pass run finished |

## Verification
The sequencer is driven through five mode patterns: a single multi-setup pass with no reads, a single-setup pass on a middle pointer, a looping run with no reader, a looping run that waits for reads, and a full-length loop drained by a slow reader. Together they separate the ordering of the list, the choice of entry, the end of a pass, the loop-back and the stall. Converter latency rotates between one and three cycles, so back-to-back and spaced done strobes are both covered. The no-reader and slow-reader loops drive the FIFO into overwrite, including the case where a read and a push land in the same cycle. Stray done strobes in idle, starts while busy and reads on an empty FIFO show whether ignored inputs leak into state.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_HOLD = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;   // store convData in the FIFO
    logic flush;  // empty FIFO, clear overflow
  } seqStrobe_t;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int NUM_SETUPS = 16,
  parameter int SETUP_W    = 12,
  parameter int DATA_W     = 24,
  localparam int IDX_W     = $clog2(NUM_SETUPS),
  localparam int PAIR_N    = NUM_SETUPS / 2,
  localparam int PAIR_AW   = $clog2(PAIR_N),
  localparam int CNT_W     = $clog2(NUM_SETUPS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 setupWrEn,
  input  logic [PAIR_AW-1:0]   setupWrAddr,
  input  logic [2*SETUP_W-1:0] setupWrData,
  input  logic [IDX_W-1:0]     activeIdx,
  output logic [SETUP_W-1:0]   activeSetup,
  input  seqStrobe_t           strobe,
  input  logic [CNT_W-1:0]     capLimit,
  input  logic [DATA_W-1:0]    pushData,
  input  logic                 rdEn,
  output logic [DATA_W-1:0]    rdData,
  output logic [CNT_W-1:0]     count,
  output logic                 empty,
  output logic                 ovf
);

  logic [SETUP_W-1:0] setupMem [NUM_SETUPS];
  logic [DATA_W-1:0]  fifoMem  [NUM_SETUPS];
  logic [IDX_W-1:0]   rdPtr, wrPtr;
  logic               full, doPop, doPush, overwrite;

  // setup storage, written one pair per word
  for (genvar p = 0; p < PAIR_N; p++) begin : g_pair
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        setupMem[2*p]   <= '0;
        setupMem[2*p+1] <= '0;
      end else if (setupWrEn && setupWrAddr == PAIR_AW'(p)) begin
        setupMem[2*p]   <= setupWrData[2*SETUP_W-1:SETUP_W];
        setupMem[2*p+1] <= setupWrData[SETUP_W-1:0];
      end
    end
  end

  assign activeSetup = setupMem[activeIdx];

  // conversion FIFO, capacity set by the pass length
  assign full      = (count >= capLimit);
  assign doPop     = rdEn && (count != '0);
  assign doPush    = strobe.push;
  assign overwrite = doPush && !doPop && full;

  always_ff @(posedge clk) begin
    if (doPush && !strobe.flush) fifoMem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else if (strobe.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop || overwrite) rdPtr <= rdPtr + 1'b1;
      if (doPush && !doPop && !full) count <= count + 1'b1;
      else if (doPop && !doPush)     count <= count - 1'b1;
      if (overwrite) ovf <= 1'b1;
    end
  end

  assign rdData = fifoMem[rdPtr];
  assign empty  = (count == '0);

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !strobe.flush) |=> ovf);  // R10
  AST_OVERWRITE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (doPush && !rdEn && full && !strobe.flush) |=> (ovf && $stable(count)));  // R10
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    (doPush && !rdEn && !full && !strobe.flush) |=> (count == CNT_W'($past(count) + 1'b1)));  // R9
  AST_EMPTY_READ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && count == '0 && !doPush && !strobe.flush) |=> (count == '0));  // R12

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
#(
  parameter int NUM_SETUPS = 16,
  localparam int IDX_W     = $clog2(NUM_SETUPS),
  localparam int CNT_W     = $clog2(NUM_SETUPS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [IDX_W-1:0] startPtr,
  input  logic             cfgLoop,
  input  logic             cfgMulti,
  input  logic             cfgWaitRead,
  input  logic [IDX_W-1:0] cfgDepth,
  input  logic             convDone,
  input  logic [CNT_W-1:0] fifoCount,
  output logic [IDX_W-1:0] activeIdx,
  output seqStrobe_t       strobe,
  output logic [CNT_W-1:0] capLimit,
  output logic             convReq,
  output logic             seqBusy,
  output logic             seqDone
);

  seqState_t        state;
  logic [IDX_W-1:0] idx, firstIdx, lastIdx;
  logic             loopR, waitR, multiR, doneR;
  logic             lastOfPass;

  assign lastOfPass = (idx == lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idx      <= '0;
      firstIdx <= '0;
      lastIdx  <= '0;
      loopR    <= 1'b0;
      waitR    <= 1'b0;
      multiR   <= 1'b0;
      doneR    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startReq) begin
          firstIdx <= cfgMulti ? '0 : startPtr;
          lastIdx  <= cfgMulti ? cfgDepth : startPtr;
          idx      <= cfgMulti ? '0 : startPtr;
          loopR    <= cfgLoop;
          waitR    <= cfgWaitRead;
          multiR   <= cfgMulti;
          doneR    <= 1'b0;
          state    <= ST_CONV;
        end
        ST_CONV: if (convDone) begin
          if (lastOfPass) begin
            if (!loopR) begin
              state <= ST_IDLE;
              doneR <= 1'b1;
            end else if (waitR) begin
              state <= ST_HOLD;
            end else begin
              idx <= firstIdx;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_HOLD: if (fifoCount == '0) begin
          state <= ST_CONV;
          idx   <= firstIdx;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign activeIdx    = idx;
  assign convReq      = (state == ST_CONV);
  assign seqBusy      = (state != ST_IDLE);
  assign seqDone      = doneR;
  assign strobe.push  = (state == ST_CONV) && convDone;
  assign strobe.flush = (state == ST_IDLE) && startReq;
  assign capLimit     = CNT_W'(lastIdx) - CNT_W'(firstIdx) + CNT_W'(1);

  AST_NEXT_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && convDone && !lastOfPass) |=> (convReq && idx == IDX_W'($past(idx) + 1'b1)));  // R4
  AST_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && !multiR) |-> (idx == firstIdx && capLimit == CNT_W'(1)));  // R5
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> (!convReq && !seqBusy));  // R6
  AST_LOOP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && convDone && lastOfPass && loopR && !waitR) |=> (convReq && idx == firstIdx));  // R7
  AST_HOLD_UNTIL_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && fifoCount != '0) |=> !convReq);  // R8

endmodule

// File: rtl/chan_seq_fifo.sv
module chan_seq_fifo
  import seq_pkg::*;
#(
  parameter int NUM_SETUPS = 16,
  parameter int SETUP_W    = 12,
  parameter int DATA_W     = 24,
  parameter int CHAN_W     = 3,
  parameter int LATCH_W    = 2,
  localparam int IDX_W     = $clog2(NUM_SETUPS),
  localparam int PAIR_AW   = $clog2(NUM_SETUPS / 2),
  localparam int CNT_W     = $clog2(NUM_SETUPS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 setupWrEn,
  input  logic [PAIR_AW-1:0]   setupWrAddr,
  input  logic [2*SETUP_W-1:0] setupWrData,
  input  logic                 cfgLoop,
  input  logic                 cfgMulti,
  input  logic                 cfgWaitRead,
  input  logic [IDX_W-1:0]     cfgDepth,
  input  logic                 startReq,
  input  logic [IDX_W-1:0]     startPtr,
  output logic                 convReq,
  output logic [SETUP_W-1:0]   convSetup,
  output logic [CHAN_W-1:0]    convChan,
  output logic [LATCH_W-1:0]   latchOut,
  input  logic                 convDone,
  input  logic [DATA_W-1:0]    convData,
  input  logic                 fifoRdEn,
  output logic [DATA_W-1:0]    fifoRdData,
  output logic                 fifoEmpty,
  output logic [CNT_W-1:0]     fifoCount,
  output logic                 fifoOvf,
  output logic                 seqBusy,
  output logic                 seqDone
);

  seqStrobe_t         strobe;
  logic [IDX_W-1:0]   activeIdx;
  logic [CNT_W-1:0]   capLimit;
  logic [SETUP_W-1:0] activeSetup;

  seq_control #(.NUM_SETUPS(NUM_SETUPS)) u_control (
    .clk(clk), .rstN(rstN),
    .startReq(startReq), .startPtr(startPtr),
    .cfgLoop(cfgLoop), .cfgMulti(cfgMulti), .cfgWaitRead(cfgWaitRead), .cfgDepth(cfgDepth),
    .convDone(convDone), .fifoCount(fifoCount),
    .activeIdx(activeIdx), .strobe(strobe), .capLimit(capLimit),
    .convReq(convReq), .seqBusy(seqBusy), .seqDone(seqDone)
  );

  seq_datapath #(.NUM_SETUPS(NUM_SETUPS), .SETUP_W(SETUP_W), .DATA_W(DATA_W)) u_datapath (
    .clk(clk), .rstN(rstN),
    .setupWrEn(setupWrEn), .setupWrAddr(setupWrAddr), .setupWrData(setupWrData),
    .activeIdx(activeIdx), .activeSetup(activeSetup),
    .strobe(strobe), .capLimit(capLimit), .pushData(convData),
    .rdEn(fifoRdEn), .rdData(fifoRdData), .count(fifoCount),
    .empty(fifoEmpty), .ovf(fifoOvf)
  );

  assign convSetup = activeSetup;
  assign convChan  = activeSetup[CHAN_W-1:0];
  assign latchOut  = activeSetup[SETUP_W-1 -: LATCH_W];

endmodule

// File: tb/chan_seq_fifo_bench.sv
module chan_seq_fifo_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setupWrEn = 1'b0;
  logic [2:0]  setupWrAddr = '0;
  logic [23:0] setupWrData = '0;
  logic        cfgLoop = 1'b0, cfgMulti = 1'b0, cfgWaitRead = 1'b0;
  logic [3:0]  cfgDepth = '0;
  logic        startReq = 1'b0;
  logic [3:0]  startPtr = '0;
  logic        convReq;
  logic [11:0] convSetup;
  logic [2:0]  convChan;
  logic [1:0]  latchOut;
  logic        convDone = 1'b0;
  logic [23:0] convData = '0;
  logic        fifoRdEn = 1'b0;
  logic [23:0] fifoRdData;
  logic        fifoEmpty;
  logic [4:0]  fifoCount;
  logic        fifoOvf, seqBusy, seqDone;

  chan_seq_fifo u_chan_seq_fifo (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFail = 0, cycles = 0, convSeen = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int mSetup[NS];
  int mq[$];
  int mState = 0, mIdx = 0, mFirst = 0, mLast = 0;
  bit mLoop = 0, mWait = 0, mDone = 0, mOvf = 0;

  function automatic logic [11:0] setupVal(int k);
    return 12'(((k % 4) << 10) | (((k * 5) & 8'h7F) << 3) | ((k ^ 5) & 7));
  endfunction

  always @(posedge clk) begin
    if (rstN) begin
      int preSize;
      bit pop, push;
      preSize = mq.size();
      pop  = fifoRdEn && preSize > 0;
      push = (mState == 1) && convDone;
      if (push) convSeen++;
      if (setupWrEn) begin
        mSetup[2*setupWrAddr]   = int'(setupWrData[23:12]);
        mSetup[2*setupWrAddr+1] = int'(setupWrData[11:0]);
      end
      if (mState == 0 && startReq) begin
        mq.delete();
        mOvf = 0; mDone = 0; mLoop = cfgLoop; mWait = cfgWaitRead;
        mFirst = cfgMulti ? 0 : int'(startPtr);
        mLast  = cfgMulti ? int'(cfgDepth) : int'(startPtr);
        mIdx = mFirst; mState = 1;
      end else begin
        if (pop) void'(mq.pop_front());
        if (push) begin
          if (mq.size() >= mLast - mFirst + 1) begin
            void'(mq.pop_front());
            mOvf = 1;
          end
          mq.push_back(int'(convData));
        end
        if (mState == 1 && push) begin
          if (mIdx == mLast) begin
            if (!mLoop) begin mState = 0; mDone = 1; end
            else if (mWait) mState = 2;
            else mIdx = mFirst;
          end else mIdx++;
        end else if (mState == 2 && preSize == 0) begin
          mState = 1; mIdx = mFirst;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R4", "convReq", 32'(convReq), 32'(mState == 1));
      chk("R6", "seqBusy", 32'(seqBusy), 32'(mState != 0));
      chk("R6", "seqDone", 32'(seqDone), 32'(mDone));
      chk("R9", "fifoCount", 32'(fifoCount), 32'(mq.size()));
      chk("R12", "fifoEmpty", 32'(fifoEmpty), 32'(mq.size() == 0));
      chk("R10", "fifoOvf", 32'(fifoOvf), 32'(mOvf));
      if (mq.size() > 0) chk("R9", "fifoRdData", 32'(fifoRdData), 32'(mq[0]));
      if (mState == 1) begin
        chk("R2", "convSetup", 32'(convSetup), 32'(mSetup[mIdx]));
        chk("R3", "convChan", 32'(convChan), 32'(mSetup[mIdx] & 7));
        chk("R3", "latchOut", 32'(latchOut), 32'((mSetup[mIdx] >> 10) & 3));
      end
    end
  end

  // converter responder with rotating latency
  bit respEn = 0;
  int waitCnt = 0, lat = 1;
  logic [23:0] dataSeed = 24'h13_5001;
  always @(negedge clk) begin
    if (respEn) begin
      if (convReq && waitCnt >= lat) begin
        convDone = 1'b1; convData = dataSeed;
        dataSeed = dataSeed + 24'h0A_3F1D;
        waitCnt = 0; lat = lat % 3 + 1;
      end else begin
        convDone = 1'b0;
        waitCnt = convReq ? waitCnt + 1 : 0;
      end
    end
  end

  // reader: 0 off, 1 read when non-empty, 2 read always, 3 every fourth cycle
  int rdMode = 0;
  always @(negedge clk) begin
    case (rdMode)
      1: fifoRdEn = !fifoEmpty;
      2: fifoRdEn = 1'b1;
      3: fifoRdEn = (cycles % 4 == 0);
      default: ;
    endcase
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; respEn = 0; rdMode = 0;
    convDone = 1'b0; fifoRdEn = 1'b0; startReq = 1'b0;
    repeat (2) @(negedge clk);
    mq.delete(); mState = 0; mIdx = 0; mFirst = 0; mLast = 0;
    mLoop = 0; mWait = 0; mDone = 0; mOvf = 0;
    foreach (mSetup[i]) mSetup[i] = 0;
    rstN = 1'b1;
  endtask

  task automatic loadSetups();
    for (int p = 0; p < NS/2; p++) begin
      @(negedge clk);
      setupWrEn = 1'b1; setupWrAddr = 3'(p);
      setupWrData = {setupVal(2*p), setupVal(2*p+1)};
    end
    @(negedge clk);
    setupWrEn = 1'b0;
  endtask

  task automatic startRun(bit lp, bit mc, bit rc, int depth, int ptr);
    @(negedge clk);
    cfgLoop = lp; cfgMulti = mc; cfgWaitRead = rc;
    cfgDepth = 4'(depth); startPtr = 4'(ptr); startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 400 && !seqDone; i++) @(negedge clk);
  endtask

  initial begin
    doReset();
    @(negedge clk);
    // R1 reset state
    chk("R1", "convReq", 32'(convReq), 0);
    chk("R1", "seqBusy", 32'(seqBusy), 0);
    chk("R1", "seqDone", 32'(seqDone), 0);
    chk("R1", "fifoOvf", 32'(fifoOvf), 0);
    chk("R1", "fifoCount", 32'(fifoCount), 0);
    chk("R1", "fifoEmpty", 32'(fifoEmpty), 1);

    // R11 / R12: stray done and empty reads while idle
    convDone = 1'b1; convData = 24'hDEAD01;
    @(negedge clk);
    convDone = 1'b0;
    chk("R11", "count after idle done", 32'(fifoCount), 0);
    rdMode = 2;
    repeat (4) @(negedge clk);
    rdMode = 0; fifoRdEn = 1'b0;
    chk("R12", "count after empty reads", 32'(fifoCount), 0);

    loadSetups();
    respEn = 1;

    // multi-setup single pass, no reads
    startRun(0, 1, 0, 5, 0);
    chk("R4", "first setup", 32'(convSetup), 32'(setupVal(0)));
    waitDone();
    chk("R6", "done after pass", 32'(seqDone), 1);
    chk("R9", "words after pass", 32'(fifoCount), 6);
    rdMode = 1;
    repeat (10) @(negedge clk);
    rdMode = 0; fifoRdEn = 1'b0;
    chk("R9", "drained", 32'(fifoEmpty), 1);

    // single setup
    startRun(0, 0, 0, 12, 9);
    chk("R5", "selected setup", 32'(convSetup), 32'(setupVal(9)));
    chk("R6", "done cleared by start", 32'(seqDone), 0);
    waitDone();
    chk("R5", "one word", 32'(fifoCount), 1);

    // loop without wait, no reader: wraps and overflows
    convSeen = 0;
    startRun(1, 1, 0, 3, 0);
    chk("R10", "start clears fifo", 32'(fifoCount), 0);
    repeat (60) @(negedge clk);
    chk("R7", "more than one pass", 32'(convSeen > 8), 1);
    chk("R10", "overflow flag", 32'(fifoOvf), 1);
    chk("R9", "count at capacity", 32'(fifoCount), 4);
    startRun(0, 0, 0, 0, 7);
    chk("R11", "start while busy ignored", 32'(seqBusy), 1);
    chk("R11", "overflow kept", 32'(fifoOvf), 1);
    repeat (10) @(negedge clk);

    // loop with wait-for-read
    doReset();
    loadSetups();
    respEn = 1;
    startRun(1, 1, 1, 2, 0);
    repeat (40) @(negedge clk);
    chk("R8", "stalled request", 32'(convReq), 0);
    chk("R8", "pass words", 32'(fifoCount), 3);
    chk("R8", "no overflow", 32'(fifoOvf), 0);
    rdMode = 1;
    repeat (40) @(negedge clk);
    chk("R8", "no overflow after reads", 32'(fifoOvf), 0);
    rdMode = 0; fifoRdEn = 1'b0;

    // full-length loop with slow reader
    doReset();
    loadSetups();
    respEn = 1;
    startRun(1, 1, 0, 15, 0);
    rdMode = 3;
    repeat (300) @(negedge clk);
    chk("R10", "slow reader overflow", 32'(fifoOvf), 1);
    rdMode = 1;
    repeat (100) @(negedge clk);
    rdMode = 0; fifoRdEn = 1'b0;

    doReset();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule